// File: doc/BRIEF.md
# Match Timer

A 32-bit up-counter with a single compare channel and one interrupt line, reached from a simple 32-bit register bus. The registers run on a fast bus clock. The counter, the compare value and the compare logic run on a separate, slower timer clock (nominally 3 MHz).

Software never reads the counter directly. It writes a request bit in the control register, polls a busy bit until the timer domain has frozen a copy, and then reads that copy. Writes to the compare value and to the counter cross into the timer domain through the same kind of toggle handshake. Each crossing holds a busy bit in the access-state register until the timer domain has acknowledged it.

Each crossing is controlled by a two-state machine. `XF_IDLE` takes the *launch* transition to `XF_WAIT` when a write is accepted: the request toggle flips and the payload is held. `XF_WAIT` takes the *return* transition back to `XF_IDLE` once the acknowledge toggle, passed back through two flip-flops, equals the request toggle. A compare hit travels to the bus domain as a toggle and sets a sticky event bit. The interrupt is asserted while an event bit and its enable bit are both 1.

Top module: `match_timer`

## Requirements
- R1: Register offsets, in bytes: compare 0x00, count 0x10, event 0x14, irq-enable 0x1C, control 0x20, access state 0x24. The compare value, the irq-enable bits [3:0] and control bit 0 read back as last accepted. Any other offset reads 0.
- R2: While control bit 0 is 1, the counter adds one on every timer clock and wraps from 0xFFFFFFFF to 0. While control bit 0 is 0, the counter holds its value.
- R3: A control write with bit 1 set requests a snapshot. Access-state bit 5 reads 1 from the next bus cycle until the copy is stable. Control bit 1 reads 1 during the same interval and 0 afterwards. A read at 0x10 then returns the value the counter had when the copy was taken.
- R4: A write to 0x00 sets access-state bit 0, and a write to 0x10 sets access-state bit 4, from the next bus cycle until the timer domain has acknowledged. A write to 0x10 loads the counter with the written value.
- R5: The event register clears, over bits [3:0], each bit written as 1, so writing 0xF clears every pending event. A hit that arrives in the same cycle as the clear wins.
- R6: A compare or count write that arrives while its own busy bit is 1 is ignored, and so is a snapshot request that arrives while bit 5 is 1.
- R7: `irq` is 1 exactly when some bit of the event register [3:0] and the same bit of irq-enable are both 1. Writing 0 to irq-enable bit 0 masks the compare event without clearing it.
- R8: After reset: the count, control, event register, irq-enable and access state are 0, the compare value is 0xFFFFFFFF, and `irq` is 0.
- R9: The compare is an exact equality. A compare value the counter has already passed produces no event until the counter wraps.
- R10: When the running counter steps onto the compare value, event bit 0 becomes 1. This includes the step onto 0xFFFFFFFF just before a wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_bus | input | 1 | Register bus clock |
| clk_tmr | input | 1 | Timer clock |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| irq | output | 1 | Interrupt request, level |

## Verification
The hardest state to reach from the ports is a second write landing while a crossing is still in `XF_WAIT`. The bench reaches it by issuing two count writes on consecutive bus cycles after the counter has been stopped. It then proves through a snapshot that only the first value reached the counter. Compare events need a running counter to step onto an exact value. The bench therefore loads a known count while the counter is stopped and steps a behavioural model of the counter on every timer clock. Against that model it checks the snapshots, the wrap onto the all-ones compare value, and the absence of an event for a compare value that lies behind the counter.

// File: rtl/mtmr_pkg.sv
package mtmr_pkg;

    typedef enum logic [0:0] {
        XF_IDLE = 1'b0,
        XF_WAIT = 1'b1
    } xf_state_e;

    // Register byte offsets
    localparam int OFS_MATCH = 'h00;
    localparam int OFS_COUNT = 'h10;
    localparam int OFS_EVENT = 'h14;
    localparam int OFS_IEN   = 'h1C;
    localparam int OFS_CTRL  = 'h20;
    localparam int OFS_ASTAT = 'h24;

    // Bit positions
    localparam int CTRL_RUN_BIT   = 0;
    localparam int CTRL_SNAP_BIT  = 1;
    localparam int ASTAT_MATCH_BIT = 0;
    localparam int ASTAT_COUNT_BIT = 4;
    localparam int ASTAT_SNAP_BIT  = 5;

endpackage

// File: rtl/mtmr_xfer.sv
// Toggle handshake carrying a held payload from the source to the destination clock.
module mtmr_xfer
    import mtmr_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk_src,
    input  logic          clk_dst,
    input  logic          rst_n,
    input  logic          start,
    input  logic [DW-1:0] din,
    output logic          busy,
    output logic          dst_pulse,
    output logic [DW-1:0] dout
);

    xf_state_e state, state_nx;
    logic          req_t;
    logic [DW-1:0] hold;
    logic          ack_s1, ack_s2;
    logic          req_s1, req_s2, req_s3;

    // state register
    always_ff @(posedge clk_src or negedge rst_n) begin
        if (!rst_n) state <= XF_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            XF_IDLE: if (start)           state_nx = XF_WAIT; // launch
            XF_WAIT: if (ack_s2 == req_t) state_nx = XF_IDLE; // return
        endcase
    end

    // outputs of the source side
    always_ff @(posedge clk_src or negedge rst_n) begin
        if (!rst_n) begin
            req_t <= 1'b0;
            hold  <= '0;
        end else if (state == XF_IDLE && start) begin
            req_t <= ~req_t;
            hold  <= din;
        end
    end

    assign busy = (state == XF_WAIT);

    // acknowledge back into the source domain
    always_ff @(posedge clk_src or negedge rst_n) begin
        if (!rst_n) begin
            ack_s1 <= 1'b0;
            ack_s2 <= 1'b0;
        end else begin
            ack_s1 <= req_s3;
            ack_s2 <= ack_s1;
        end
    end

    // destination side
    always_ff @(posedge clk_dst or negedge rst_n) begin
        if (!rst_n) begin
            req_s1 <= 1'b0;
            req_s2 <= 1'b0;
            req_s3 <= 1'b0;
        end else begin
            req_s1 <= req_t;
            req_s2 <= req_s1;
            req_s3 <= req_s2;
        end
    end

    assign dst_pulse = req_s2 ^ req_s3;
    assign dout      = hold;

endmodule

// File: rtl/mtmr_evsync.sv
// Carries a toggle-coded event into the receiving clock as a one-cycle pulse.
module mtmr_evsync (
    input  logic clk,
    input  logic rst_n,
    input  logic tgl_in,
    output logic pulse
);

    logic s1, s2, s3;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1 <= 1'b0;
            s2 <= 1'b0;
            s3 <= 1'b0;
        end else begin
            s1 <= tgl_in;
            s2 <= s1;
            s3 <= s2;
        end
    end

    assign pulse = s2 ^ s3;

endmodule

// File: rtl/mtmr_core.sv
// Timer-domain counter, compare register, snapshot latch.
module mtmr_core #(
    parameter int CW = 32
) (
    input  logic          clk_tmr,
    input  logic          rst_n,
    input  logic          run_async,
    input  logic          ld_pulse,
    input  logic [CW-1:0] ld_val,
    input  logic          mt_pulse,
    input  logic [CW-1:0] mt_val,
    input  logic          snap_req,
    output logic          run,
    output logic [CW-1:0] cnt,
    output logic [CW-1:0] snap_val,
    output logic          hit_tgl
);

    logic          run_s1;
    logic [CW-1:0] cmp_q;
    logic [CW-1:0] cnt_inc;

    assign cnt_inc = cnt + CW'(1);

    always_ff @(posedge clk_tmr or negedge rst_n) begin
        if (!rst_n) begin
            run_s1 <= 1'b0;
            run    <= 1'b0;
        end else begin
            run_s1 <= run_async;
            run    <= run_s1;
        end
    end

    always_ff @(posedge clk_tmr or negedge rst_n) begin
        if (!rst_n)        cnt <= '0;
        else if (ld_pulse) cnt <= ld_val;
        else if (run)      cnt <= cnt_inc;
    end

    always_ff @(posedge clk_tmr or negedge rst_n) begin
        if (!rst_n)        cmp_q <= '1;
        else if (mt_pulse) cmp_q <= mt_val;
    end

    always_ff @(posedge clk_tmr or negedge rst_n) begin
        if (!rst_n)                                hit_tgl <= 1'b0;
        else if (run && !ld_pulse && cnt_inc == cmp_q) hit_tgl <= ~hit_tgl;
    end

    always_ff @(posedge clk_tmr or negedge rst_n) begin
        if (!rst_n)        snap_val <= '0;
        else if (snap_req) snap_val <= cnt;
    end

endmodule

// File: rtl/match_timer.sv
module match_timer
    import mtmr_pkg::*;
#(
    parameter int CW = 32,
    parameter int AW = 6,
    parameter int SW = 4
) (
    input  logic          clk_bus,
    input  logic          clk_tmr,
    input  logic          rst_n,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [31:0]   bus_wdata,
    output logic [31:0]   bus_rdata,
    output logic          irq
);

    logic          wr_hit;
    logic          match_go, count_go, snap_go;
    logic          match_busy, count_busy, snap_busy;
    logic [CW-1:0] match_shadow;
    logic          ctrl_run;
    logic [SW-1:0] stat_q, ier_q, stat_clr;
    logic          hit_b;
    logic          mt_pulse, ld_pulse, sn_pulse, sn_tag;
    logic [CW-1:0] mt_val, ld_val, cnt, snap_val;
    logic          run, hit_tgl;

    assign wr_hit   = bus_sel & bus_wr;
    assign match_go = wr_hit && bus_addr == AW'(OFS_MATCH) && !match_busy;
    assign count_go = wr_hit && bus_addr == AW'(OFS_COUNT) && !count_busy;
    assign snap_go  = wr_hit && bus_addr == AW'(OFS_CTRL) && bus_wdata[CTRL_SNAP_BIT] && !snap_busy;

    mtmr_xfer #(.DW(CW)) u_mt_xf (
        .clk_src(clk_bus), .clk_dst(clk_tmr), .rst_n(rst_n),
        .start(match_go), .din(bus_wdata[CW-1:0]),
        .busy(match_busy), .dst_pulse(mt_pulse), .dout(mt_val)
    );

    mtmr_xfer #(.DW(CW)) u_ld_xf (
        .clk_src(clk_bus), .clk_dst(clk_tmr), .rst_n(rst_n),
        .start(count_go), .din(bus_wdata[CW-1:0]),
        .busy(count_busy), .dst_pulse(ld_pulse), .dout(ld_val)
    );

    mtmr_xfer #(.DW(1)) u_sn_xf (
        .clk_src(clk_bus), .clk_dst(clk_tmr), .rst_n(rst_n),
        .start(snap_go), .din(1'b1),
        .busy(snap_busy), .dst_pulse(sn_pulse), .dout(sn_tag)
    );

    mtmr_core #(.CW(CW)) u_core (
        .clk_tmr(clk_tmr), .rst_n(rst_n), .run_async(ctrl_run),
        .ld_pulse(ld_pulse), .ld_val(ld_val),
        .mt_pulse(mt_pulse), .mt_val(mt_val),
        .snap_req(sn_pulse & sn_tag),
        .run(run), .cnt(cnt), .snap_val(snap_val), .hit_tgl(hit_tgl)
    );

    mtmr_evsync u_hit_sync (
        .clk(clk_bus), .rst_n(rst_n), .tgl_in(hit_tgl), .pulse(hit_b)
    );

    // bus-side registers
    always_ff @(posedge clk_bus or negedge rst_n) begin
        if (!rst_n) match_shadow <= '1;
        else if (match_go) match_shadow <= bus_wdata[CW-1:0];
    end

    always_ff @(posedge clk_bus or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_run <= 1'b0;
            ier_q    <= '0;
        end else if (wr_hit) begin
            if (bus_addr == AW'(OFS_CTRL)) ctrl_run <= bus_wdata[CTRL_RUN_BIT];
            if (bus_addr == AW'(OFS_IEN))  ier_q    <= bus_wdata[SW-1:0];
        end
    end

    assign stat_clr = (wr_hit && bus_addr == AW'(OFS_EVENT)) ? bus_wdata[SW-1:0] : '0;

    always_ff @(posedge clk_bus or negedge rst_n) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~stat_clr) | {{(SW-1){1'b0}}, hit_b};
    end

    assign irq = |(stat_q & ier_q);

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            AW'(OFS_MATCH): bus_rdata = 32'(match_shadow);
            AW'(OFS_COUNT): bus_rdata = 32'(snap_val);
            AW'(OFS_EVENT): bus_rdata = 32'(stat_q);
            AW'(OFS_IEN):   bus_rdata = 32'(ier_q);
            AW'(OFS_CTRL): begin
                bus_rdata[CTRL_RUN_BIT]  = ctrl_run;
                bus_rdata[CTRL_SNAP_BIT] = snap_busy;
            end
            AW'(OFS_ASTAT): begin
                bus_rdata[ASTAT_MATCH_BIT] = match_busy;
                bus_rdata[ASTAT_COUNT_BIT] = count_busy;
                bus_rdata[ASTAT_SNAP_BIT]  = snap_busy;
            end
            default: bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/mtmr_chk.sv
module mtmr_chk
    import mtmr_pkg::*;
#(
    parameter int CW = 32,
    parameter int AW = 6,
    parameter int SW = 4
) (
    input logic          clk_bus,
    input logic          clk_tmr,
    input logic          rst_n,
    input logic          irq,
    input logic          wr_hit,
    input logic [AW-1:0] bus_addr,
    input logic [31:0]   bus_wdata,
    input logic [SW-1:0] stat_q,
    input logic          hit_b,
    input logic          match_busy,
    input logic [CW-1:0] match_shadow,
    input logic          run,
    input logic          ld_pulse,
    input logic [CW-1:0] cnt
);

    assert_irq_cause_R7: assert property (@(posedge clk_bus) disable iff (!rst_n)
        $rose(irq) |-> ($past(hit_b) || $past(wr_hit && bus_addr == AW'(OFS_IEN))));

    assert_busy_ignore_R6: assert property (@(posedge clk_bus) disable iff (!rst_n)
        (wr_hit && bus_addr == AW'(OFS_MATCH) && match_busy) |=> $stable(match_shadow));

    assert_w1c_clear_R5: assert property (@(posedge clk_bus) disable iff (!rst_n)
        (wr_hit && bus_addr == AW'(OFS_EVENT) && bus_wdata[0] && !hit_b) |=> !stat_q[0]);

    assert_match_busy_R4: assert property (@(posedge clk_bus) disable iff (!rst_n)
        (wr_hit && bus_addr == AW'(OFS_MATCH) && !match_busy) |=> match_busy);

    assert_count_step_R2: assert property (@(posedge clk_tmr) disable iff (!rst_n)
        (run && !ld_pulse) |=> (cnt == $past(cnt) + CW'(1)));

    assert_count_hold_R2: assert property (@(posedge clk_tmr) disable iff (!rst_n)
        (!run && !ld_pulse) |=> $stable(cnt));

endmodule

bind match_timer mtmr_chk #(.CW(CW), .AW(AW), .SW(SW)) u_mtmr_chk (
    .clk_bus(clk_bus), .clk_tmr(clk_tmr), .rst_n(rst_n), .irq(irq),
    .wr_hit(wr_hit), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .stat_q(stat_q), .hit_b(hit_b), .match_busy(match_busy),
    .match_shadow(match_shadow), .run(run), .ld_pulse(ld_pulse), .cnt(cnt)
);

// File: tb/test_match_timer.sv
`timescale 1ns/1ps
module test_match_timer;

    localparam logic [5:0] A_MATCH = 6'h00, A_COUNT = 6'h10, A_EVENT = 6'h14,
                           A_IEN = 6'h1C, A_CTRL = 6'h20, A_ASTAT = 6'h24;

    logic        clk_bus = 1'b0, clk_tmr = 1'b0, rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0, errors = 0;

    // reference model state
    logic [31:0] m_cnt = '0;
    logic        m_run = 1'b0;
    logic [3:0]  m_ien = '0;
    bit          mon_on = 1'b0;

    always #2  clk_bus = ~clk_bus;   // 250 MHz
    always #19 clk_tmr = ~clk_tmr;   // timer clock

    match_timer i_match_timer (
        .clk_bus(clk_bus), .clk_tmr(clk_tmr), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    // behavioural counter model, one step per timer clock
    always @(posedge clk_tmr) if (m_run) m_cnt = m_cnt + 32'd1;

    // per-clock comparison: R7 masked irq stays low
    always @(negedge clk_bus) begin
        if (mon_on) begin
            checks++;
            if (m_ien == 4'd0 && irq !== 1'b0) begin
                errors++;
                $display("FAIL R7 irq while masked act=%b exp=0", irq);
            end
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic check_near(input string tag, input logic [31:0] act, input int lo, input int hi);
        int d;
        d = int'(act - m_cnt);
        checks++;
        if (d < lo || d > hi) begin
            errors++;
            $display("FAIL %s act=%h exp=%h(%0d..%0d)", tag, act, m_cnt, lo, hi);
        end
    endtask

    task automatic bwrite(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk_bus);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk_bus);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bread(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk_bus);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic wait_idle(input logic [31:0] mask);
        logic [31:0] v;
        for (int i = 0; i < 400; i++) begin
            bread(A_ASTAT, v);
            if ((v & mask) == 0) return;
        end
        check("R4 busy never cleared", v & mask, 32'd0);
    endtask

    task automatic snapshot(output logic [31:0] v);
        bwrite(A_CTRL, {30'd0, 1'b1, m_run});
        wait_idle(32'h20);
        bread(A_COUNT, v);
    endtask

    task automatic set_run(input logic r);
        bwrite(A_CTRL, {31'd0, r});
        m_run = r;
        repeat (4) @(posedge clk_tmr);
    endtask

    task automatic load_count(input logic [31:0] v);
        bwrite(A_COUNT, v);
        m_cnt = v;
        wait_idle(32'h10);
    endtask

    initial begin
        #2_000_000;
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v, v2;
        repeat (3) @(negedge clk_bus);
        rst_n = 1'b1;
        mon_on = 1'b1;

        // R8 reset state
        bread(A_MATCH, v); check("R8 compare reset", v, 32'hFFFF_FFFF);
        bread(A_EVENT, v); check("R8 event reset", v, 0);
        bread(A_IEN, v);   check("R8 ien reset", v, 0);
        bread(A_CTRL, v);  check("R8 control reset", v, 0);
        bread(A_ASTAT, v); check("R8 access reset", v, 0);
        check("R8 irq reset", {31'd0, irq}, 0);
        snapshot(v);       check("R8 count reset", v, 0);

        // R1 readback and unmapped offset
        bwrite(A_IEN, 32'h0000_0006); bread(A_IEN, v); check("R1 ien readback", v, 32'h6);
        bwrite(A_IEN, 32'h0); 
        bread(6'h08, v); check("R1 unmapped reads 0", v, 0);

        // R4 count write busy and load; R3 snapshot busy and self-clear
        bwrite(A_COUNT, 32'h0000_0100); m_cnt = 32'h100;
        bread(A_ASTAT, v); check("R4 count busy", v & 32'h10, 32'h10);
        wait_idle(32'h10);
        bwrite(A_CTRL, 32'h2);
        bread(A_ASTAT, v); check("R3 snapshot busy", v & 32'h20, 32'h20);
        bread(A_CTRL, v);  check("R3 ctrl bit1 during", v & 32'h2, 32'h2);
        wait_idle(32'h20);
        bread(A_CTRL, v);  check("R3 ctrl bit1 cleared", v & 32'h2, 0);
        bread(A_COUNT, v); check("R3 latched count", v, 32'h100);

        // R2 counting against model, then hold
        set_run(1'b1);
        bread(A_CTRL, v); check("R1 ctrl run readback", v & 32'h1, 32'h1);
        repeat (100) @(posedge clk_tmr);
        snapshot(v);  check_near("R2 running count", v, -12, 2);
        set_run(1'b0);
        snapshot(v);
        repeat (30) @(posedge clk_tmr);
        snapshot(v2); check("R2 hold when stopped", v2, v);

        // R6 second count write during busy ignored
        @(negedge clk_bus);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = A_COUNT; bus_wdata = 32'h0000_5000;
        @(negedge clk_bus); bus_wdata = 32'h0000_9000;
        @(negedge clk_bus); bus_sel = 1'b0; bus_wr = 1'b0;
        m_cnt = 32'h5000;
        wait_idle(32'h10);
        snapshot(v); check("R6 ignored count write", v, 32'h5000);

        // R4/R6 compare write busy, second write ignored
        @(negedge clk_bus);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = A_MATCH; bus_wdata = 32'h0000_0028;
        @(negedge clk_bus); bus_wdata = 32'h0000_7777;
        @(negedge clk_bus); bus_sel = 1'b0; bus_wr = 1'b0;
        bread(A_ASTAT, v); check("R4 compare busy", v & 32'h1, 32'h1);
        wait_idle(32'h1);
        bread(A_MATCH, v); check("R6 ignored compare write", v, 32'h28);
        bwrite(A_MATCH, 32'hFFFF_FFFF); wait_idle(32'h1);

        // R2 wrap and R10 hit on all-ones compare
        load_count(32'hFFFF_FFF0);
        set_run(1'b1);
        repeat (40) @(posedge clk_tmr);
        snapshot(v); check_near("R2 wrap", v, -12, 2);
        check("R2 wrapped below 64", {31'd0, (v < 32'd64)}, 32'd1);
        bread(A_EVENT, v); check("R10 hit at all-ones", v & 32'h1, 32'h1);
        bwrite(A_EVENT, 32'hF);
        bread(A_EVENT, v); check("R5 w1c clears", v, 0);

        // R7 masked event, then unmask; R10 hit at compare 40
        set_run(1'b0);
        load_count(32'd0);
        bwrite(A_MATCH, 32'd40); wait_idle(32'h1);
        set_run(1'b1);
        repeat (120) @(posedge clk_tmr);
        bread(A_EVENT, v); check("R10 hit at compare", v & 32'h1, 32'h1);
        check("R7 masked irq low", {31'd0, irq}, 0);
        bwrite(A_IEN, 32'h1); m_ien = 4'h1;
        @(negedge clk_bus); check("R7 irq after unmask", {31'd0, irq}, 1);
        bwrite(A_IEN, 32'h0); m_ien = 4'h0;
        @(negedge clk_bus); check("R7 irq masked again", {31'd0, irq}, 0);
        bread(A_EVENT, v); check("R7 mask keeps event", v & 32'h1, 32'h1);
        bwrite(A_EVENT, 32'hF);
        bread(A_EVENT, v); check("R5 w1c all bits", v, 0);

        // R9 compare already passed: no event
        set_run(1'b0);
        load_count(32'd100);
        set_run(1'b1);
        repeat (150) @(posedge clk_tmr);
        bread(A_EVENT, v); check("R9 passed compare silent", v, 0);
        check("R9 irq low", {31'd0, irq}, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule